// File: doc/BRIEF.md
# Seconds Counter with Alarm and Tick Interrupts

This block is a memory-mapped real-time clock. An input strobe runs at the 32.768 kHz oscillator rate. A programmable prescaler counts these strobes and emits a one-second tick. Each tick advances a 32-bit seconds counter and compares the new count with a 32-bit alarm value. On a match the block latches an alarm pending flag. Every tick also latches a tick pending flag. Two interrupt lines come from these flags, each gated by its own enable bit.

Software reaches four registers over a single-cycle register port: the counter, the alarm, a configuration word holding the divider and the trim, and a status word. In the status word the two enables are ordinary read/write bits and the two pending flags are write-one-to-clear. A configuration word of zero counts as unprogrammed, so the prescaler falls back to the standard one-second divide. A nonzero trim lengthens some tick periods by one strobe, which gives fine frequency correction. A parameter chooses between two address layouts.

Top module: `rtc_tick_alarm`

## Requirements
- R1: After reset the counter, alarm, configuration and status registers all read zero, and both interrupt lines are low.
- R2: With a nonzero configuration word whose divider field (bits 15:0) is D, a tick occurs on every (D+1)-th strobe of ref_pulse. Cycles without a strobe do not advance the prescaler.
- R3: While the whole configuration word is zero, the divider is 32767. The first tick after reset then comes on the 32768th strobe.
- R4: A trim field T (bits 25:16) makes the first T ticks of every 1024-tick cycle take D+2 strobes instead of D+1.
- R5: Each tick adds one to the counter, wrapping from 0xFFFFFFFF to 0. A write to the counter sets it directly and wins over a tick in the same cycle.
- R6: Status bit 0, the alarm pending flag, is set at the tick edge whose incremented count equals the alarm register.
- R7: Status bit 1, the tick pending flag, is set at every tick edge.
- R8: Writing a one to status bit 0 or bit 1 clears that flag, and writing zero leaves it unchanged. If an event sets a flag in the same cycle as a clear, the flag ends up set.
- R9: Status bit 2 (alarm enable) and bit 3 (tick enable) are plain read/write bits. irq_alarm is high while bit 0 and bit 2 are both set. irq_second is high while bit 1 and bit 3 are both set. Writing zero to the status register drops both lines.
- R10: With MAP_SEL=0 the offsets are alarm 0x00, counter 0x04, configuration 0x08, status 0x10. With MAP_SEL=1 they are counter 0x0, alarm 0x4, status 0x8, configuration 0xC. Other offsets read zero and ignore writes.
- R11: The configuration register keeps bits 25:0 of the written word, and its upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | One-cycle strobe at the oscillator rate |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | Access is a write when high |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_second | output | 1 | One-second tick interrupt |

## Verification
Read data is combinational from the address, so the bench samples it one quarter-period after driving the address, before the next edge. The register update from a write, and the counter and flag update from a tick, land on the next rising edge. The interrupt lines follow the flags with no further delay, so the bench compares them with its reference model at every falling edge. Interval checks on the prescaler read the counter a fixed number of cycles apart, and the expected difference follows from the strobe count over that window.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef enum logic [2:0] {
      REG_NONE,
      REG_CNT,
      REG_ALM,
      REG_CFG,
      REG_STAT
   } rtc_reg_e;

   // status layout: bit3 tick enable, bit2 alarm enable, bit1 tick flag, bit0 alarm flag
   typedef struct packed {
      logic tk_en;
      logic al_en;
      logic tk_flag;
      logic al_flag;
   } rtc_stat_t;

   localparam int STAT_W = 4;
endpackage

// File: rtl/rtc_regdecode.sv
module rtc_regdecode
   import rtc_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int MAP_SEL = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output rtc_reg_e          reg_sel
);
   generate
      if (MAP_SEL == 0) begin : g_map_a
         always_comb begin
            case (addr)
               ADDR_W'('h00): reg_sel = REG_ALM;
               ADDR_W'('h04): reg_sel = REG_CNT;
               ADDR_W'('h08): reg_sel = REG_CFG;
               ADDR_W'('h10): reg_sel = REG_STAT;
               default:       reg_sel = REG_NONE;
            endcase
         end
      end else begin : g_map_b
         always_comb begin
            case (addr)
               ADDR_W'('h0): reg_sel = REG_CNT;
               ADDR_W'('h4): reg_sel = REG_ALM;
               ADDR_W'('h8): reg_sel = REG_STAT;
               ADDR_W'('hC): reg_sel = REG_CFG;
               default:      reg_sel = REG_NONE;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV_W     = 16,
   parameter int TRIM_W    = 10,
   parameter int DEF_DIV   = 32767,
   parameter int TRIM_SPAN = 1024,
   localparam int CFG_W    = DIV_W + TRIM_W,
   localparam int PH_W     = $clog2(TRIM_SPAN),
   localparam int CMP_W    = ((TRIM_W > PH_W) ? TRIM_W : PH_W) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_pulse,
   input  logic [CFG_W-1:0] cfg_word,
   output logic             tick
);
   logic [DIV_W:0]    pcnt_q;
   logic [PH_W-1:0]   ph_q;
   logic [DIV_W-1:0]  div_eff;
   logic [TRIM_W-1:0] trim_eff;
   logic              stretch;
   logic [DIV_W:0]    limit;

   always_comb begin
      if (cfg_word == '0) begin
         div_eff  = DIV_W'(DEF_DIV);
         trim_eff = '0;
      end else begin
         div_eff  = cfg_word[DIV_W-1:0];
         trim_eff = cfg_word[DIV_W +: TRIM_W];
      end
      stretch = CMP_W'(ph_q) < CMP_W'(trim_eff);
      limit   = {1'b0, div_eff} + (DIV_W+1)'(stretch);
      tick    = ref_pulse && (pcnt_q >= limit);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt_q <= '0;
         ph_q   <= '0;
      end else if (ref_pulse) begin
         if (tick) begin
            pcnt_q <= '0;
            ph_q   <= ph_q + PH_W'(1);
         end else begin
            pcnt_q <= pcnt_q + (DIV_W+1)'(1);
         end
      end
   end
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cnt_we,
   input  logic              alm_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cnt_q,
   output logic [DATA_W-1:0] alarm_q,
   output logic              alarm_hit
);
   logic [DATA_W-1:0] cnt_inc;

   assign cnt_inc   = cnt_q + DATA_W'(1);
   assign alarm_hit = tick && (cnt_inc == alarm_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         alarm_q <= '0;
      end else begin
         if (cnt_we)     cnt_q <= wdata;
         else if (tick)  cnt_q <= cnt_inc;
         if (alm_we)     alarm_q <= wdata;
      end
   end
endmodule

// File: rtl/rtc_status.sv
module rtc_status
   import rtc_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [STAT_W-1:0] wdata,
   input  logic            alarm_evt,
   input  logic            tick_evt,
   output rtc_stat_t       stat_q,
   output logic            irq_alarm,
   output logic            irq_second
);
   rtc_stat_t wr_view;
   assign wr_view = rtc_stat_t'(wdata);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else begin
         if (wr_en) begin
            stat_q.tk_en <= wr_view.tk_en;
            stat_q.al_en <= wr_view.al_en;
         end
         stat_q.al_flag <= alarm_evt | (stat_q.al_flag & ~(wr_en & wr_view.al_flag));
         stat_q.tk_flag <= tick_evt  | (stat_q.tk_flag & ~(wr_en & wr_view.tk_flag));
      end
   end

   assign irq_alarm  = stat_q.al_flag & stat_q.al_en;
   assign irq_second = stat_q.tk_flag & stat_q.tk_en;
endmodule

// File: rtl/rtc_tick_alarm.sv
module rtc_tick_alarm
   import rtc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int DIV_W     = 16,
   parameter int TRIM_W    = 10,
   parameter int DEF_DIV   = 32767,
   parameter int TRIM_SPAN = 1024,
   parameter int ADDR_W    = 5,
   parameter int MAP_SEL   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_pulse,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_alarm,
   output logic              irq_second
);
   localparam int CFG_W = DIV_W + TRIM_W;

   generate
      if (CFG_W > DATA_W) begin : g_err_cfg
         $error("divider plus trim field exceeds data width");
      end
      if (MAP_SEL == 0 && ADDR_W < 5) begin : g_err_addr_a
         $error("layout 0 needs at least 5 address bits");
      end
      if (MAP_SEL != 0 && ADDR_W < 4) begin : g_err_addr_b
         $error("layout 1 needs at least 4 address bits");
      end
      if (TRIM_SPAN < 2 || (TRIM_SPAN & (TRIM_SPAN - 1)) != 0) begin : g_err_span
         $error("trim span must be a power of two of at least 2");
      end
      if (DEF_DIV < 1 || DEF_DIV >= (1 << DIV_W)) begin : g_err_div
         $error("default divider does not fit the divider field");
      end
      if (DATA_W < STAT_W) begin : g_err_data
         $error("data width too small for status word");
      end
   endgenerate

   rtc_reg_e          reg_sel;
   logic              wr_any;
   logic              cnt_we, alm_we, cfg_we, stat_we;
   logic [CFG_W-1:0]  cfg_q;
   logic              sec_tick;
   logic              alarm_hit;
   logic [DATA_W-1:0] cnt_q, alarm_q;
   rtc_stat_t         stat_q;

   rtc_regdecode #(.ADDR_W(ADDR_W), .MAP_SEL(MAP_SEL)) u_dec (
      .addr    (bus_addr),
      .reg_sel (reg_sel)
   );

   assign wr_any  = bus_sel & bus_wr;
   assign cnt_we  = wr_any && (reg_sel == REG_CNT);
   assign alm_we  = wr_any && (reg_sel == REG_ALM);
   assign cfg_we  = wr_any && (reg_sel == REG_CFG);
   assign stat_we = wr_any && (reg_sel == REG_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_we) cfg_q <= bus_wdata[CFG_W-1:0];
   end

   rtc_prescaler #(
      .DIV_W(DIV_W), .TRIM_W(TRIM_W), .DEF_DIV(DEF_DIV), .TRIM_SPAN(TRIM_SPAN)
   ) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_pulse (ref_pulse),
      .cfg_word  (cfg_q),
      .tick      (sec_tick)
   );

   rtc_timebase #(.DATA_W(DATA_W)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sec_tick),
      .cnt_we    (cnt_we),
      .alm_we    (alm_we),
      .wdata     (bus_wdata),
      .cnt_q     (cnt_q),
      .alarm_q   (alarm_q),
      .alarm_hit (alarm_hit)
   );

   rtc_status u_st (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (stat_we),
      .wdata      (bus_wdata[STAT_W-1:0]),
      .alarm_evt  (alarm_hit),
      .tick_evt   (sec_tick),
      .stat_q     (stat_q),
      .irq_alarm  (irq_alarm),
      .irq_second (irq_second)
   );

   always_comb begin
      case (reg_sel)
         REG_CNT:  bus_rdata = cnt_q;
         REG_ALM:  bus_rdata = alarm_q;
         REG_CFG:  bus_rdata = DATA_W'(cfg_q);
         REG_STAT: bus_rdata = DATA_W'(stat_q);
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rtc_tick_alarm_chk.sv
module rtc_tick_alarm_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_pulse,
   input logic              sec_tick,
   input logic [DATA_W-1:0] cnt_q,
   input logic [DATA_W-1:0] alarm_q,
   input logic              cnt_we,
   input logic              stat_we,
   input logic [DATA_W-1:0] wdata,
   input logic [3:0]        stat_q,
   input logic              irq_alarm,
   input logic              irq_second
);
   a_r2_tick_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> ref_pulse);

   a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !cnt_we) |=> (cnt_q == $past(cnt_q) + DATA_W'(1)));

   a_r5_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !cnt_we) |=> $stable(cnt_q));

   a_r6_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && (cnt_q + DATA_W'(1) == alarm_q)) |=> stat_q[0]);

   a_r7_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> stat_q[1]);

   a_r8_w1c_alarm: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && wdata[0] && !(sec_tick && (cnt_q + DATA_W'(1) == alarm_q))) |=> !stat_q[0]);

   a_r8_w1c_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && wdata[1] && !sec_tick) |=> !stat_q[1]);

   a_r9_alarm_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && !wdata[2]) |=> !irq_alarm);

   a_r9_tick_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && !wdata[3]) |=> !irq_second);
endmodule

bind rtc_tick_alarm rtc_tick_alarm_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ref_pulse  (ref_pulse),
   .sec_tick   (sec_tick),
   .cnt_q      (cnt_q),
   .alarm_q    (alarm_q),
   .cnt_we     (cnt_we),
   .stat_we    (stat_we),
   .wdata      (bus_wdata),
   .stat_q     (stat_q),
   .irq_alarm  (irq_alarm),
   .irq_second (irq_second)
);

// File: tb/rtc_tick_alarm_bench.sv
module rtc_tick_alarm_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] A_ALM  = 5'h00;
   localparam logic [4:0] A_CNT  = 5'h04;
   localparam logic [4:0] A_CFG  = 5'h08;
   localparam logic [4:0] A_STAT = 5'h10;
   localparam logic [4:0] A_HOLE = 5'h0C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_pulse = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_alarm, irq_second;

   int n_chk = 0;
   int n_fail = 0;
   int ref_mode = 0;
   bit ref_phase = 1'b0;
   bit cmp_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_tick_alarm u_rtc_tick_alarm (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_alarm(irq_alarm), .irq_second(irq_second)
   );

   // ---------------- reference model ----------------
   bit [31:0] m_cnt, m_alm;
   bit [25:0] m_cfg;
   bit        m_alf, m_tkf, m_ale, m_tke;
   int        m_pre, m_ph;

   always @(posedge clk) begin : model
      int  d, t, lim;
      bit  tk, hit;
      bit  [31:0] nxt;
      if (!rst_n) begin
         m_cnt = 0; m_alm = 0; m_cfg = 0;
         m_alf = 0; m_tkf = 0; m_ale = 0; m_tke = 0;
         m_pre = 0; m_ph = 0;
      end else begin
         if (m_cfg == 0) begin d = 32767; t = 0; end
         else begin d = int'(m_cfg[15:0]); t = int'(m_cfg[25:16]); end
         tk = 1'b0;
         if (ref_pulse) begin
            lim = d + ((m_ph < t) ? 1 : 0);
            if (m_pre >= lim) begin
               tk = 1'b1; m_pre = 0; m_ph = (m_ph + 1) % 1024;
            end else m_pre = m_pre + 1;
         end
         nxt = m_cnt + 32'd1;
         hit = tk && (nxt == m_alm);
         if (bus_sel && bus_wr && bus_addr == A_STAT) begin
            m_alf = hit | (m_alf & ~bus_wdata[0]);
            m_tkf = tk  | (m_tkf & ~bus_wdata[1]);
            m_ale = bus_wdata[2];
            m_tke = bus_wdata[3];
         end else begin
            m_alf = m_alf | hit;
            m_tkf = m_tkf | tk;
         end
         if (tk) m_cnt = nxt;
         if (bus_sel && bus_wr) begin
            case (bus_addr)
               A_CNT: m_cnt = bus_wdata;
               A_ALM: m_alm = bus_wdata;
               A_CFG: m_cfg = bus_wdata[25:0];
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] mread(input logic [4:0] a);
      case (a)
         A_CNT:  return m_cnt;
         A_ALM:  return m_alm;
         A_CFG:  return {6'd0, m_cfg};
         A_STAT: return {28'd0, m_tke, m_ale, m_tkf, m_alf};
         default: return 32'd0;
      endcase
   endfunction

   // ---------------- check helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      case (ref_mode)
         0: ref_pulse = 1'b1;
         1: begin ref_phase = ~ref_phase; ref_pulse = ref_phase; end
         default: ref_pulse = 1'b0;
      endcase
   end

   // R9: interrupt lines against the model on every clock
   always @(negedge clk) begin
      if (cmp_on) begin
         #1;
         chk(irq_alarm == (m_alf & m_ale), "R9 irq_alarm", 32'(irq_alarm), 32'(m_alf & m_ale));
         chk(irq_second == (m_tkf & m_tke), "R9 irq_second", 32'(irq_second), 32'(m_tkf & m_tke));
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input string req, output logic [31:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #(CLK_PERIOD/4);
      v = bus_rdata;
      chk(v == mread(a), req, v, mread(a));
      bus_sel = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      logic [31:0] v, v1, v2;
      ref_mode = 2;
      idle(4);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      // R1: reset state
      rd(A_CNT,  "R1 counter", v);  chk(v == 0, "R1 counter zero", v, 0);
      rd(A_ALM,  "R1 alarm", v);    chk(v == 0, "R1 alarm zero", v, 0);
      rd(A_CFG,  "R1 config", v);   chk(v == 0, "R1 config zero", v, 0);
      rd(A_STAT, "R1 status", v);   chk(v == 0, "R1 status zero", v, 0);
      chk(!irq_alarm && !irq_second, "R1 irq low", {30'd0, irq_alarm, irq_second}, 0);

      // R3: default divide with zero configuration
      ref_mode = 0;
      idle(32800);
      rd(A_CNT, "R3 counter", v);   chk(v == 1, "R3 one tick after 32768 strobes", v, 1);
      rd(A_STAT, "R7 status", v);   chk(v == 32'h2, "R7 tick flag set", v, 32'h2);

      // R10: hole in the map
      wr(A_HOLE, 32'hFFFF_FFFF);
      rd(A_HOLE, "R10 hole reads zero", v);
      rd(A_ALM, "R10 alarm untouched", v);
      rd(A_CFG, "R10 config untouched", v);

      // R11: config width
      wr(A_CFG, 32'hFFFF_FFFF);
      rd(A_CFG, "R11 config", v);   chk(v == 32'h03FF_FFFF, "R11 upper bits zero", v, 32'h03FF_FFFF);

      // R2: divide by 4
      wr(A_CFG, 32'd3);
      wr(A_CNT, 32'd100);
      idle(3);
      rd(A_CNT, "R2 counter", v1);
      idle(39);
      rd(A_CNT, "R2 counter", v2);
      chk(v2 - v1 == 10, "R2 ten ticks in 40 strobes", v2 - v1, 10);
      ref_mode = 1;
      rd(A_CNT, "R2 gated counter", v1);
      idle(79);
      rd(A_CNT, "R2 gated counter", v2);
      chk(v2 - v1 == 10, "R2 ten ticks in 80 cycles at half rate", v2 - v1, 10);
      ref_mode = 2;
      rd(A_CNT, "R2 stalled counter", v1);
      idle(49);
      rd(A_CNT, "R2 stalled counter", v2);
      chk(v2 == v1, "R2 no strobes no ticks", v2, v1);

      // R5/R6: wrap with alarm at zero
      ref_mode = 0;
      wr(A_CNT, 32'hFFFF_FFFD);
      wr(A_ALM, 32'd0);
      wr(A_STAT, 32'h7);
      idle(20);
      chk(irq_alarm == 1'b1, "R6 alarm at wrap to zero", 32'(irq_alarm), 1);
      rd(A_CNT, "R5 wrapped counter", v);
      chk(v < 32'd10, "R5 counter wrapped", v, 32'd0);
      rd(A_STAT, "R6 status", v);

      // R8: write zero keeps flag, write one clears
      wr(A_STAT, 32'h4);
      rd(A_STAT, "R8 status", v);   chk(v[0] == 1'b1, "R8 zero keeps alarm flag", v, 32'h1);
      wr(A_STAT, 32'h5);
      rd(A_STAT, "R8 status", v);   chk(v[0] == 1'b0, "R8 one clears alarm flag", v, 0);
      chk(irq_alarm == 1'b0, "R8 alarm irq dropped", 32'(irq_alarm), 0);

      // R9: tick interrupt and full disable
      wr(A_STAT, 32'hA);
      idle(6);
      chk(irq_second == 1'b1, "R9 tick irq raised", 32'(irq_second), 1);
      wr(A_STAT, 32'h0);
      chk(!irq_alarm && !irq_second, "R9 zero write drops both", {30'd0, irq_alarm, irq_second}, 0);
      rd(A_STAT, "R9 status enables off", v);
      chk(v[3:2] == 2'b00, "R9 enables cleared", v, 0);

      // R8: clears racing with ticks
      for (int i = 0; i < 12; i++) begin
         wr(A_STAT, 32'h3);
         rd(A_STAT, "R8 clear race", v);
      end

      // R4: trim on 1023 of 1024 ticks
      wr(A_CFG, (32'd1023 << 16) | 32'd3);
      rd(A_CNT, "R4 counter", v1);
      idle(499);
      rd(A_CNT, "R4 counter", v2);
      chk((v2 - v1 >= 99) && (v2 - v1 <= 101), "R4 stretched period", v2 - v1, 100);
      wr(A_CFG, (32'd2 << 16) | 32'd3);
      for (int i = 0; i < 1300; i++) begin
         idle(5);
         rd(A_CNT, "R4 trimmed counter", v);
      end

      cmp_on = 1'b0;
      idle(2);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule